// File: doc/BRIEF.md
# Programmable Square-Wave Beeper

This block produces an audible square wave for a small processor system. It is clocked from the processor bus clock. A fixed binary prescaler divides that clock by a power of two. Each prescaler tick then steps a programmable period counter. The sounder pin follows the most significant bit of that counter. Software sets the pitch by writing a single period register, which it can also read back at the same address.

A period of zero keeps the sounder silent. Any accepted write clears the prescaler and the period counter, so each new tone starts from phase zero. With the default widths (a 7-bit prescaler and an 8-bit period counter), a period of `P` produces one cycle of the waveform every `128*P` bus clocks. The output is high only while the count has its top bit set, which needs a period of more than 128.

A small state machine sequences the counters. It has three states:
- `ST_MUTE`: the period is zero, and the counters are held at zero.
- `ST_ARM`: a one-cycle settling state after a non-zero write.
- `ST_RUN`: the counters run.

It has these transitions:
- **go_arm**: any state to `ST_ARM` on a write of a non-zero value.
- **go_mute**: any state to `ST_MUTE` on a write of zero.
- **arm_done**: `ST_ARM` to `ST_RUN` on the next cycle.
- **keep**: otherwise the state holds.

Top module: `tone_gen_top`

## Requirements
- R1: After reset the period register reads 0 and `snd_out` is 0.
- R2: A read with `bus_addr` equal to `REG_ADDR` returns the period register on `bus_rdata`. Any other address returns 0.
- R3: A write is accepted only when `bus_sel` and `bus_we` are both 1 and `bus_addr` equals `REG_ADDR`. Any other access leaves the period register and the running waveform unchanged.
- R4: While the period register holds 0, `snd_out` stays 0.
- R5: The prescaler divides the clock by D = 2^PRE_W. After a write accepted at clock edge 0, the period count first advances at edge D+1. It then advances once every D edges, so after edge n (n ≥ 1) it has advanced floor((n-1)/D) times.
- R6: The period counter counts 0, 1, …, P-1 and then wraps to 0, where P is the period. One waveform cycle therefore lasts P*D clocks.
- R7: `snd_out` equals the most significant bit (bit PER_W-1) of the period count while running. It is 1 exactly when the count is ≥ 2^(PER_W-1).
- R8: Every accepted write, including a rewrite of the same value, clears both counters, so the waveform restarts from count 0.
- R9: For a period of at most 2^(PER_W-1), `snd_out` never goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Block select |
| bus_we | input | 1 | Write enable (1 = write) |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | PER_W | Write data (new period) |
| bus_rdata | output | PER_W | Readback data |
| snd_out | output | 1 | Square-wave sounder output |

## Verification
The bench builds the block with PRE_W = 3 and PER_W = 4, so the prescaler divides by 8 and the period counter spans 0 to 15. With these widths a full waveform cycle takes at most 120 clocks. This lets the bench follow several complete cycles at the longest period, the wrap at P-1, and the high phase that starts when the count reaches 8. It also lets the bench confirm that periods at or below 8 stay low, and that a rewrite in mid-cycle restarts the phase, all within a short run.

// File: rtl/tone_pkg.sv
`timescale 1ns/1ps
package tone_pkg;

    // Sequencing states of the period divider.
    typedef enum logic [1:0] {
        ST_MUTE = 2'd0,   // period is zero, counters held
        ST_ARM  = 2'd1,   // one settling cycle after a non-zero write
        ST_RUN  = 2'd2    // counters advance
    } tone_state_e;

endpackage

// File: rtl/tone_regif.sv
`timescale 1ns/1ps
module tone_regif #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int REG_ADDR = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wr_stb,
    output logic [DATA_W-1:0] period_q
);

    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

    logic hit;

    always_comb begin
        hit    = (bus_addr == MY_ADDR);
        wr_stb = bus_sel && bus_we && hit;
    end

    // Period register, silent after reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= '0;
        end else if (wr_stb) begin
            period_q <= bus_wdata;
        end
    end

    // Readback of the period register at its own address only.
    always_comb begin
        bus_rdata = hit ? period_q : '0;
    end

    // R3: no accepted write, no change of the register
    p_reg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(period_q));

    // R2: an accepted write lands in the register
    p_reg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (period_q == $past(bus_wdata)));

endmodule

// File: rtl/tone_prescaler.sv
`timescale 1ns/1ps
module tone_prescaler #(
    parameter int PRE_W = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic tick
);

    logic [PRE_W-1:0] pre_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else if (clr || !run) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    always_comb begin
        tick = run && (pre_cnt == '1);
    end

    // R5: prescaler ticks are never back to back
    p_tick_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/tone_divider.sv
`timescale 1ns/1ps
module tone_divider
    import tone_pkg::*;
#(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [PER_W-1:0] wr_val,
    input  logic [PER_W-1:0] period,
    input  logic             tick,
    output logic             run,
    output logic             snd
);

    localparam int MSB = PER_W - 1;

    tone_state_e state, state_nx;
    logic [PER_W-1:0] cnt;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_MUTE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic: go_mute, go_arm, arm_done, keep.
    always_comb begin
        state_nx = state;
        if (wr_stb) begin
            state_nx = (wr_val == '0) ? ST_MUTE : ST_ARM;
        end else begin
            unique case (state)
                ST_MUTE: state_nx = ST_MUTE;
                ST_ARM:  state_nx = ST_RUN;
                ST_RUN:  state_nx = ST_RUN;
                default: state_nx = ST_MUTE;
            endcase
        end
    end

    // Period counter: 0 .. period-1, advanced by prescaler ticks.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (wr_stb || (state != ST_RUN)) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == period - 1'b1) ? '0 : cnt + 1'b1;
        end
    end

    // Outputs.
    always_comb begin
        run = (state == ST_RUN);
        snd = run && cnt[MSB];
    end

    // R6: a running count always stays below the period
    p_cnt_below_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (cnt < period));

    // R8: an accepted write clears the count and leaves the run state
    p_write_restarts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> ((cnt == '0) && (state != ST_RUN)));

    // R5: the count only moves on a prescaler tick
    p_hold_between_ticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RUN) && !tick && !wr_stb) |=> $stable(cnt));

endmodule

// File: rtl/tone_gen_top.sv
`timescale 1ns/1ps
module tone_gen_top #(
    parameter int PRE_W    = 7,
    parameter int PER_W    = 8,
    parameter int ADDR_W   = 4,
    parameter int REG_ADDR = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PER_W-1:0]  bus_wdata,
    output logic [PER_W-1:0]  bus_rdata,
    output logic              snd_out
);

    logic             wr_stb;
    logic [PER_W-1:0] period_q;
    logic             run;
    logic             tick;

    tone_regif #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (PER_W),
        .REG_ADDR (REG_ADDR)
    ) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wr_stb    (wr_stb),
        .period_q  (period_q)
    );

    tone_prescaler #(
        .PRE_W (PRE_W)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clr   (wr_stb),
        .tick  (tick)
    );

    tone_divider #(
        .PER_W (PER_W)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (wr_stb),
        .wr_val (bus_wdata),
        .period (period_q),
        .tick   (tick),
        .run    (run),
        .snd    (snd_out)
    );

    // R4: a zero period keeps the sounder low
    p_mute_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (period_q == '0) |-> !snd_out);

endmodule

// File: tb/tone_gen_top_bench.sv
`timescale 1ns/1ps
module tone_gen_top_bench;

    localparam int PRE_W    = 3;
    localparam int PER_W    = 4;
    localparam int ADDR_W   = 4;
    localparam int REG_ADDR = 5;
    localparam int D        = 1 << PRE_W;
    localparam int HALF     = 1 << (PER_W - 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [PER_W-1:0]  bus_wdata = '0;
    logic [PER_W-1:0]  bus_rdata;
    logic              snd_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tone_gen_top #(
        .PRE_W    (PRE_W),
        .PER_W    (PER_W),
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) u_tone_gen_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .snd_out   (snd_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected sounder level n edges after a write of period p.
    function automatic int exp_snd(input int p, input int n);
        int adv;
        if (p == 0 || n < 1) return 0;
        adv = (n - 1) / D;
        return ((adv % p) >= HALF) ? 1 : 0;
    endfunction

    // Bus access that spans one clock edge; it returns at the negedge after that edge.
    task automatic bus_access(input bit sel, input bit we, input int addr, input int data);
        bus_sel   = sel;
        bus_we    = we;
        bus_addr  = ADDR_W'(addr);
        bus_wdata = PER_W'(data);
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0;
        bus_we  = 1'b0;
    endtask

    task automatic read_reg(input int addr, output int val);
        bus_addr = ADDR_W'(addr);
        #0.5;
        val = int'(bus_rdata);
        bus_addr = '0;
    endtask

    // Follow the waveform for n = first .. last edges after the write.
    task automatic follow(input string req, input int p, input int first, input int last);
        for (int n = first; n <= last; n++) begin
            @(negedge clk);
            check(req, int'(snd_out), exp_snd(p, n));
        end
    endtask

    task automatic t_reset();
        int v;
        check("R1 snd after reset", int'(snd_out), 0);
        read_reg(REG_ADDR, v);
        check("R1 period after reset", v, 0);
    endtask

    task automatic t_readback();
        int v;
        bus_access(1'b1, 1'b1, REG_ADDR, 11);
        read_reg(REG_ADDR, v);
        check("R2 readback of period", v, 11);
        read_reg(REG_ADDR + 1, v);
        check("R2 other address reads zero", v, 0);
    endtask

    task automatic t_waveform(input int p);
        bus_access(1'b1, 1'b1, REG_ADDR, p);
        follow("R5 R6 R7 waveform", p, 1, 3 * p * D + 4);
    endtask

    task automatic t_ignored();
        int v;
        bus_access(1'b1, 1'b1, REG_ADDR, 12);
        follow("R3 before ignored writes", 12, 1, 40);
        bus_access(1'b1, 1'b1, REG_ADDR + 2, 3);            // wrong address
        check("R3 snd after wrong-address write", int'(snd_out), exp_snd(12, 41));
        bus_access(1'b0, 1'b1, REG_ADDR, 3);                // not selected
        check("R3 snd after unselected write", int'(snd_out), exp_snd(12, 42));
        bus_access(1'b1, 1'b0, REG_ADDR, 3);                // read cycle
        check("R3 snd after read cycle", int'(snd_out), exp_snd(12, 43));
        follow("R3 phase kept", 12, 44, 200);
        read_reg(REG_ADDR, v);
        check("R3 period kept", v, 12);
    endtask

    task automatic t_low_period(input int p);
        bus_access(1'b1, 1'b1, REG_ADDR, p);
        for (int n = 1; n <= 4 * p * D; n++) begin
            @(negedge clk);
            check("R9 short period stays low", int'(snd_out), 0);
        end
    endtask

    task automatic t_zero();
        int v;
        bus_access(1'b1, 1'b1, REG_ADDR, 15);
        follow("R7 run before mute", 15, 1, 100);
        bus_access(1'b1, 1'b1, REG_ADDR, 0);
        for (int n = 1; n <= 300; n++) begin
            @(negedge clk);
            check("R4 zero period silent", int'(snd_out), 0);
        end
        read_reg(REG_ADDR, v);
        check("R4 zero readback", v, 0);
    endtask

    task automatic t_restart();
        bus_access(1'b1, 1'b1, REG_ADDR, 13);
        follow("R8 before rewrite", 13, 1, 75);
        bus_access(1'b1, 1'b1, REG_ADDR, 13);
        follow("R8 phase restarts after rewrite", 13, 1, 2 * 13 * D);
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_waveform(15);
        t_waveform(12);
        t_waveform(9);
        t_ignored();
        t_low_period(8);
        t_low_period(3);
        t_zero();
        t_restart();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule